// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block lets software reach the management registers of external Ethernet PHYs and switches over the two-wire MDIO bus, using Clause 22 framing. Software works through a small 32-bit register port addressed by byte offset. It stores a PHY and register address, and for a write it also stores the value to send. It then launches the transfer through a command word, polls a busy flag in the same word, and finally collects the 16-bit result of a read.

The management clock is derived from the system clock by a parameterised divider, and it runs only while a transfer is in flight. The bidirectional data line is presented as three separate signals: a driven value, an output enable, and the sampled input. The pad itself sits outside the block. Each transfer is one fixed-length frame, and it completes within a bounded number of system cycles. Software can therefore poll with a plain retry limit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy reads as 0, MDC is low, the MDIO output enable is low, and the address, write-data, read-data and command registers all read as zero.
- R2: Offset 0x44 holds a 16-bit address word, with the PHY address in bits [15:8] and the register number in bits [7:0]. Offset 0x48 holds the 16-bit write value in bits [15:0]. Both read back exactly what was written, and upper bits read as zero.
- R3: In the command word at offset 0x50, a write with bit 8 set starts a transfer, and bit 0 selects the access: 0 is a read, 1 is a write. Bit 8 always reads back as 0, bit 0 reads back as the last accepted access code, and bit 16 reads as 1 from the cycle after the start until the transfer ends.
- R4: While busy is 1, a write to the command word has no effect. The running transfer keeps its kind and its length, and the stored access code is unchanged. This also holds for a command write that lands in the very cycle busy clears.
- R5: A write transfer emits, MSB first, 32 ones, then start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the 16-bit write value. The output enable is high for all 64 bits.
- R6: A read transfer emits 32 ones, then 01, opcode 10, the PHY address and the register address. It then releases the line (output enable low) for the 2 turnaround bits and the 16 data bits. It samples MDIO on each rising MDC edge of the data phase, MSB first, and the result reads back from offset 0x4C once busy is 0.
- R7: Only bits [12:8] and [4:0] of the address word reach the frame. The upper three bits of each byte are ignored.
- R8: MDC stays low while idle. During a transfer, each MDC half period lasts exactly HALF_CYC system cycles, which is 25 by default, giving 2 MHz from 100 MHz.
- R9: MDIO output and output enable change only while MDC is low, and only at least HOLD_CYC cycles after its falling edge. The line is released whenever the block is idle.
- R10: Reads of unmapped offsets return zero, and writes to them change no register and start nothing.
- R11: Busy stays high for exactly 2*HALF_CYC*64 system cycles per transfer, which is 3200 by default and well under 1 ms.
- R12: The read-data register keeps the result of the last read transfer. A write transfer does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable, active high |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The sharpest collision is a start request that arrives in the same cycle the running frame completes. In that cycle busy is still set, so the request must be dropped and must not chain a new frame. The bench times a command write onto exactly the edge at which the end of the frame clears busy. It also reads the command word one cycle earlier and expects busy still at 1. A following read must then show busy at 0 and the old access code. Register reads that overlap a running frame are also mixed into the random transfers. These checks confirm that the live busy bit and the held read data never tear.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int CMD_CODE_BIT  = 0;
  localparam int CMD_START_BIT = 8;
  localparam int CMD_BUSY_BIT  = 16;

  localparam int BODY_BITS = 32;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } access_e;

  typedef struct packed {
    access_e     code;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } xfer_req_t;

  // Frame body after the preamble: start, opcode, addresses, turnaround, data.
  function automatic logic [BODY_BITS-1:0] frame_body(input xfer_req_t r);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] d;
    op = (r.code == ACC_WRITE) ? 2'b01 : 2'b10;
    ta = (r.code == ACC_WRITE) ? 2'b10 : 2'b11;
    d  = (r.code == ACC_WRITE) ? r.data : 16'hFFFF;
    return {2'b01, op, r.phy, r.regn, ta, d};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_CYC = 25,
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic launch,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (at_last) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mdc    = mdc_q;
  assign launch = en && !mdc_q && (cnt_q == HOLD);
  assign rise   = en && !mdc_q && at_last;
  assign fall   = en &&  mdc_q && at_last;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  xfer_req_t   req,
  input  logic        launch,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int FRAME    = PRE_LEN + BODY_BITS;
  localparam int CW       = $clog2(FRAME + 1);
  localparam int REL_IDX  = PRE_LEN + 14;
  localparam int DATA_IDX = PRE_LEN + 16;

  logic             busy_q;
  logic [CW-1:0]    bit_cnt_q;
  logic [FRAME-1:0] shift_q;
  logic             is_rd_q;
  logic [15:0]      rx_q;
  logic [15:0]      rd_data_q;
  logic             o_q;
  logic             oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      is_rd_q   <= 1'b0;
      rx_q      <= '0;
      rd_data_q <= '0;
      o_q       <= 1'b1;
      oe_q      <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q    <= 1'b1;
        bit_cnt_q <= '0;
        shift_q   <= {{PRE_LEN{1'b1}}, frame_body(req)};
        is_rd_q   <= (req.code == ACC_READ);
      end
    end else begin
      if (launch && (bit_cnt_q < CW'(FRAME))) begin
        o_q     <= shift_q[FRAME-1];
        oe_q    <= !(is_rd_q && (bit_cnt_q >= CW'(REL_IDX)));
        shift_q <= {shift_q[FRAME-2:0], 1'b1};
      end
      if (rise) begin
        if (is_rd_q && (bit_cnt_q >= CW'(DATA_IDX)))
          rx_q <= {rx_q[14:0], mdio_i};
        bit_cnt_q <= bit_cnt_q + CW'(1);
      end
      if (fall && (bit_cnt_q == CW'(FRAME))) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
        o_q    <= 1'b1;
        if (is_rd_q)
          rd_data_q <= rx_q;
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign rd_data = rd_data_q;

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic [15:0]       rd_result,
  output logic              start,
  output xfer_req_t         req
);
  localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(OFS_ADDR);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);

  logic [15:0] addr_q;
  logic [15:0] wdata_q;
  logic        code_q;
  logic [31:0] rdata_q;
  logic        cmd_wr;
  logic        unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:16]};
  assign cmd_wr = reg_wr && (reg_addr == A_CMD) && !busy;
  assign start  = cmd_wr && reg_wdata[CMD_START_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      code_q  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_ADDR)  addr_q  <= reg_wdata[15:0];
      if (reg_addr == A_WDATA) wdata_q <= reg_wdata[15:0];
      if (cmd_wr)              code_q  <= reg_wdata[CMD_CODE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (reg_addr == A_ADDR)  rdata_q[15:0] <= addr_q;
      if (reg_addr == A_WDATA) rdata_q[15:0] <= wdata_q;
      if (reg_addr == A_RDATA) rdata_q[15:0] <= rd_result;
      if (reg_addr == A_CMD) begin
        rdata_q[CMD_BUSY_BIT] <= busy;
        rdata_q[CMD_CODE_BIT] <= code_q;
      end
    end
  end

  assign reg_rdata = rdata_q;

  always_comb begin
    req.code = access_e'(reg_wdata[CMD_CODE_BIT]);
    req.phy  = addr_q[12:8];
    req.regn = addr_q[4:0];
    req.data = wdata_q;
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_CYC = 25,
  parameter int HOLD_CYC = 3,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        xfer_busy;
  logic        xfer_start;
  xfer_req_t   xfer_req;
  logic [15:0] rd_result;
  logic        ev_launch;
  logic        ev_rise;
  logic        ev_fall;

  mdio_csr #(.ADDR_W(ADDR_W)) csr_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (xfer_busy),
    .rd_result (rd_result),
    .start     (xfer_start),
    .req       (xfer_req)
  );

  mdio_mdc_gen #(.HALF_CYC(HALF_CYC), .HOLD_CYC(HOLD_CYC)) mdc_i (
    .clk    (clk),
    .rst    (rst),
    .en     (xfer_busy),
    .mdc    (mdc),
    .launch (ev_launch),
    .rise   (ev_rise),
    .fall   (ev_fall)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) eng_i (
    .clk     (clk),
    .rst     (rst),
    .start   (xfer_start),
    .req     (xfer_req),
    .launch  (ev_launch),
    .rise    (ev_rise),
    .fall    (ev_fall),
    .mdio_i  (mdio_i),
    .busy    (xfer_busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_data (rd_result)
  );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_CYC = 25,
  parameter int HOLD_CYC = 3,
  parameter int PRE_LEN  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  localparam int TOTAL = 2 * HALF_CYC * (PRE_LEN + BODY_BITS);

  logic prev_mdc;
  int   high_run;
  int   low_run;
  int   busy_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mdc <= 1'b0;
      high_run <= 0;
      low_run  <= 1000;
      busy_run <= 0;
    end else begin
      prev_mdc <= mdc;
      high_run <= mdc ? high_run + 1 : 0;
      low_run  <= mdc ? 0 : ((low_run < 1000) ? low_run + 1 : low_run);
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  // R3: busy only rises after a start write to the command word
  assert_start_source_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && (reg_addr == ADDR_W'(OFS_CMD)) && reg_wdata[CMD_START_BIT]));

  // R8: MDC idles low
  assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R8: each high phase lasts exactly HALF_CYC cycles
  assert_mdc_high_width_R8: assert property (@(posedge clk) disable iff (rst)
    (prev_mdc && !mdc) |-> (high_run == HALF_CYC));

  // R9: line changes only in the low phase, after the hold margin
  assert_launch_margin_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)))
      |-> (!mdc && low_run >= HOLD_CYC));

  // R9: released while idle
  assert_release_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R11: bounded and exact transfer length
  assert_busy_bound_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < TOTAL));

  assert_busy_exact_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == TOTAL));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(
  .ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC), .HOLD_CYC(HOLD_CYC), .PRE_LEN(PRE_LEN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (xfer_busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int HALF   = 25;
  localparam int XFER   = 2 * HALF * 64;
  localparam logic [7:0] A_ADDR = 8'h44, A_WD = 8'h48, A_RD = 8'h4C, A_CMD = 8'h50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: capture bits on MDC rise, answer reads after MDC fall
  logic [63:0] sh_o = '0;
  logic [63:0] sh_oe = '0;
  int          rise_total = 0;
  int          base = 0;
  logic [15:0] phy_val = '0;
  time         last_rise_t = 0;
  time         per_t = 0;

  always @(posedge mdc) begin
    sh_o  = {sh_o[62:0], mdio_o};
    sh_oe = {sh_oe[62:0], mdio_oe};
    per_t = $time - last_rise_t;
    last_rise_t = $time;
    rise_total++;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_total - base;
    if (k >= 48 && k < 64) mdio_i = phy_val[63-k];
    else if (k == 47)      mdio_i = 1'b0;
    else                   mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      reg_read(A_CMD, v);
      if (!v[16]) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [7:0] p,
                                            input logic [7:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p[4:0], r[4:0],
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
  endfunction

  logic [63:0] rd_oe_mask = {{46{1'b1}}, 18'b0};
  logic [15:0] last_rd = '0;

  task automatic do_xfer(input bit wr, input logic [7:0] p, input logic [7:0] r,
                         input logic [15:0] d, input logic [15:0] resp);
    logic [31:0] v;
    logic [63:0] ef;
    reg_write(A_ADDR, {16'h0, p, r});
    if (wr) reg_write(A_WD, {16'h0, d});
    phy_val = resp;
    base = rise_total;
    reg_write(A_CMD, 32'h100 | {31'h0, wr});
    reg_read(A_CMD, v);
    check(v[16] == 1'b1 && v[8] == 1'b0, "R3 busy set, start self-clears", {32'h0, v}, 64'h10000);
    // overlapping register read while the frame runs
    reg_read(A_RD, v);
    check(v[15:0] == last_rd, "R12 read data held during transfer", {48'h0, v[15:0]}, {48'h0, last_rd});
    wait_idle();
    ef = exp_frame(wr, p, r, d);
    if (wr) begin
      check(sh_o == ef, "R5 R7 write frame bits", sh_o, ef);
      check(sh_oe == '1, "R5 write drives all bits", sh_oe, '1);
    end else begin
      check(sh_o[63:18] == ef[63:18], "R6 R7 read frame header", sh_o, ef);
      check(sh_oe == rd_oe_mask, "R6 read release window", sh_oe, rd_oe_mask);
      reg_read(A_RD, v);
      check(v == {16'h0, resp}, "R6 read result", {32'h0, v}, {48'h0, resp});
      last_rd = resp;
    end
    reg_read(A_CMD, v);
    check(v == {31'h0, wr}, "R3 code readback, busy clear", {32'h0, v}, {63'h0, wr});
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 R9 idle MDC low, line released",
          {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 MDC and enable low", {62'h0, mdc, mdio_oe}, 64'h0);
    reg_read(A_CMD, v);   check(v == 0, "R1 command word zero", {32'h0, v}, 64'h0);
    reg_read(A_ADDR, v);  check(v == 0, "R1 address zero", {32'h0, v}, 64'h0);
    reg_read(A_RD, v);    check(v == 0, "R1 read data zero", {32'h0, v}, 64'h0);

    // R2: readback
    reg_write(A_ADDR, 32'hFFFF_A5C3);
    reg_read(A_ADDR, v);  check(v == 32'h0000_A5C3, "R2 address readback", {32'h0, v}, 64'hA5C3);
    reg_write(A_WD, 32'h1234_BEEF);
    reg_read(A_WD, v);    check(v == 32'h0000_BEEF, "R2 write-data readback", {32'h0, v}, 64'hBEEF);

    // R10: unmapped offsets
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_write(8'h54, 32'h0000_0101);
    reg_write(8'h51, 32'h0000_0101);
    reg_read(8'h54, v);   check(v == 0, "R10 unmapped reads zero", {32'h0, v}, 64'h0);
    reg_read(A_ADDR, v);  check(v == 32'hA5C3, "R10 unmapped write harmless", {32'h0, v}, 64'hA5C3);
    reg_read(A_CMD, v);   check(v == 0, "R10 no start from unmapped", {32'h0, v}, 64'h0);

    // directed transfers
    do_xfer(1'b1, 8'h01, 8'h00, 16'h8000, 16'h0);
    do_xfer(1'b0, 8'h1F, 8'h1F, 16'h0, 16'hA55A);
    check(per_t == time'(2 * HALF * 10), "R8 MDC period", per_t, 2 * HALF * 10);
    do_xfer(1'b0, 8'hE3, 8'hA9, 16'h0, 16'h0001);   // R7 upper address bits ignored
    do_xfer(1'b1, 8'hFF, 8'hFF, 16'hFFFF, 16'h0);   // R12 write keeps last read
    reg_read(A_RD, v);
    check(v == 32'h0001, "R12 write leaves read data", {32'h0, v}, 64'h1);

    // R4: start while busy ignored
    reg_write(A_ADDR, {16'h0, 8'h05, 8'h02});
    phy_val = 16'h3C3C;
    base = rise_total;
    reg_write(A_CMD, 32'h100);
    repeat (200) @(negedge clk);
    reg_write(A_CMD, 32'h101);
    reg_read(A_CMD, v);
    check(v == 32'h0001_0000, "R4 busy write keeps code", {32'h0, v}, 64'h10000);
    wait_idle();
    check(sh_oe == rd_oe_mask, "R4 transfer still a read", sh_oe, rd_oe_mask);
    reg_read(A_RD, v);
    check(v == 32'h3C3C, "R4 read result intact", {32'h0, v}, 64'h3C3C);
    last_rd = 16'h3C3C;

    // R4 R11: start request in the exact cycle busy clears
    base = rise_total;
    phy_val = 16'h0F0F;
    reg_write(A_CMD, 32'h100);
    repeat (XFER - 2) @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_CMD;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata[16] == 1'b1, "R11 busy still set one cycle before end",
          {63'h0, reg_rdata[16]}, 64'h1);
    reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h101;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_read(A_CMD, v);
    check(v == 32'h0, "R4 R11 start at completion edge dropped", {32'h0, v}, 64'h0);
    reg_read(A_RD, v);
    check(v == 32'h0F0F, "R6 result after back-to-back edge", {32'h0, v}, 64'h0F0F);
    last_rd = 16'h0F0F;

    // constrained random transfers
    for (int i = 0; i < 8; i++) begin
      bit          w;
      logic [7:0]  p, r;
      logic [15:0] d, resp;
      w = 1'($urandom_range(0, 1));
      p = 8'($urandom); r = 8'($urandom);
      d = 16'($urandom); resp = 16'($urandom);
      do_xfer(w, p, r, d, resp);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule